// File: doc/BRIEF.md
# CAN Error Status and Interrupt Controller

This block sits beside a CAN protocol engine. It turns the engine's receive and transmit error counters into a five-bit fault-confinement status and tracks per-buffer receive overflow. It raises one combined error interrupt and one wake-up interrupt, both routed through a small register file that software reads and clears. The error counters, the acceptance filters and the bit engine stay outside. This block only watches their outputs.

Each counter feeds its own copy of a four-state level machine: `LVL_OK`, `LVL_WARN`, `LVL_PASSIVE` and `LVL_BUSOFF`. Every state can move to any other when the counter crosses a threshold. The transitions are OK→WARN/PASSIVE/BUSOFF when the count rises, WARN→OK/PASSIVE/BUSOFF, PASSIVE→OK/WARN/BUSOFF, and BUSOFF→OK/WARN/PASSIVE when the ninth count bit clears. The machine always lands in the level that matches the last sampled count. When any status bit differs from its value one cycle earlier, the error interrupt flag is set.

The same flag is also set when a message passes the filters and its target buffer is still full. The wake-up flag is set when the synchronised receive line goes from recessive to dominant while the chip sleeps. Software clears flags by writing 1 to them. A set in the same cycle wins over a clear. A clear is also refused while its cause is still present.

Top module: `can_err_irq_ctrl`

## Requirements
- R1: Status bit 0 (receive warning) is 1 from the cycle after the receive count is sampled at 96 or more, and 0 otherwise.
- R2: Status bit 1 (transmit warning) is 1 from the cycle after the transmit count is sampled at 96 or more, or with its ninth bit set.
- R3: Status bit 2 (receive passive) and bit 3 (transmit passive) are 1 one cycle after their count is sampled above 127; a set ninth transmit bit also sets bit 3.
- R4: Status bit 4 (bus-off) is 1 one cycle after the ninth transmit count bit is sampled high; it implies bits 1 and 3.
- R5: A message accepted with buffer index i set overflow flag i (register 3, bit i) at that edge when buffer i is full. The flag stays set until a 1 is written to its bit. An index at or above the buffer count is ignored.
- R6: Error flag (register 1, bit 0) is set one cycle after any status bit changes, and at the same edge as any overflow flag is set.
- R7: Wake flag (register 1, bit 1) is set two cycles after the receive line falls from 1 to 0 while the sleep input is high. A fall while awake does not set it.
- R8: The interrupt request equals the OR of the flags in register 1 ANDed with the enables in register 2 (bit 0 error, bit 1 wake). Register 2 is read/write.
- R9: Writing 1 to the error flag is ignored while any overflow flag is set. Writing 1 to the wake flag is ignored while sleep is high and the synchronised line is dominant.
- R10: When a flag's set condition and a write-1 clear meet in the same cycle, the flag ends set.
- R11: Synchronous reset clears status, flags, overflow flags and enables.
- R12: Register 0 returns the status. Writes to register 0 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_err_cnt | input | CNT_W | Receive error count |
| tx_err_cnt | input | CNT_W | Transmit error count, low bits |
| tx_err_cnt_ovf | input | 1 | Ninth transmit count bit |
| msg_accept | input | 1 | Strobe: a message passed the filters |
| msg_buf_idx | input | IDX_W | Buffer tied to the matching filter |
| buf_full | input | NUM_BUF | Per-buffer full flags |
| sleep_mode | input | 1 | Chip is sleeping |
| can_rx | input | 1 | Asynchronous receive line, 1 = recessive |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 status, 1 flags, 2 enables, 3 overflow) |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for reg_addr |
| status | output | 5 | {bus-off, tx passive, rx passive, tx warn, rx warn} |
| irq_flags | output | 2 | {wake, error} flags |
| ovf_flags | output | NUM_BUF | Per-buffer overflow flags |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with three buffers, a two-bit index and eight-bit counters. An index value of 3 then names no buffer, which exercises the ignored-index path of R5. It also makes the overflow register's unused upper write bits observable. Count values of 95, 96, 127, 128 and 255, plus the ninth bit, drive every level-machine transition, including direct jumps such as OK to BUSOFF. With only three buffers, a random phase often makes filter hits collide with write-1 clears, so the set-over-clear rule and the refused clears are hit many times.

// File: rtl/can_eic_pkg.sv
package can_eic_pkg;
    typedef enum logic [1:0] {
        LVL_OK      = 2'd0,
        LVL_WARN    = 2'd1,
        LVL_PASSIVE = 2'd2,
        LVL_BUSOFF  = 2'd3
    } err_lvl_e;

    localparam int REG_ADDR_W = 2;
    localparam logic [REG_ADDR_W-1:0] ADDR_STATUS = 2'd0;
    localparam logic [REG_ADDR_W-1:0] ADDR_FLAGS  = 2'd1;
    localparam logic [REG_ADDR_W-1:0] ADDR_ENABLE = 2'd2;
    localparam logic [REG_ADDR_W-1:0] ADDR_OVF    = 2'd3;

    localparam int ST_RX_WARN = 0;
    localparam int ST_TX_WARN = 1;
    localparam int ST_RX_PASS = 2;
    localparam int ST_TX_PASS = 3;
    localparam int ST_BUS_OFF = 4;
    localparam int STATUS_W   = 5;

    localparam int FLG_ERR  = 0;
    localparam int FLG_WAKE = 1;
    localparam int FLAG_W   = 2;
endpackage

// File: rtl/err_level_fsm.sv
module err_level_fsm
    import can_eic_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int WARN_LVL    = 96,
    parameter int PASSIVE_LVL = 127
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cnt,
    input  logic             cnt_ovf,
    output logic             warn,
    output logic             passive,
    output logic             bus_off
);
    err_lvl_e state_q, state_d;
    logic     hit_warn, hit_pass;

    assign hit_warn = cnt_ovf | (cnt >= CNT_W'(WARN_LVL));
    assign hit_pass = cnt_ovf | (cnt >  CNT_W'(PASSIVE_LVL));

    always_ff @(posedge clk) begin
        if (rst) state_q <= LVL_OK;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LVL_OK: begin
                if (cnt_ovf)       state_d = LVL_BUSOFF;
                else if (hit_pass) state_d = LVL_PASSIVE;
                else if (hit_warn) state_d = LVL_WARN;
            end
            LVL_WARN: begin
                if (cnt_ovf)        state_d = LVL_BUSOFF;
                else if (hit_pass)  state_d = LVL_PASSIVE;
                else if (!hit_warn) state_d = LVL_OK;
            end
            LVL_PASSIVE: begin
                if (cnt_ovf)        state_d = LVL_BUSOFF;
                else if (!hit_warn) state_d = LVL_OK;
                else if (!hit_pass) state_d = LVL_WARN;
            end
            LVL_BUSOFF: begin
                if (!cnt_ovf) begin
                    if (hit_pass)      state_d = LVL_PASSIVE;
                    else if (hit_warn) state_d = LVL_WARN;
                    else               state_d = LVL_OK;
                end
            end
            default: state_d = LVL_OK;
        endcase
    end

    always_comb begin
        warn    = (state_q != LVL_OK);
        passive = (state_q == LVL_PASSIVE) || (state_q == LVL_BUSOFF);
        bus_off = (state_q == LVL_BUSOFF);
    end
endmodule

// File: rtl/rx_activity_det.sv
module rx_activity_det #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic rx_in,
    output logic line,
    output logic fall
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '1;
            prev_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], rx_in};
            prev_q <= sync_q[SYNC_STAGES-1];
        end
    end

    assign line = sync_q[SYNC_STAGES-1];
    assign fall = prev_q & ~sync_q[SYNC_STAGES-1];
endmodule

// File: rtl/sticky_flag.sv
module sticky_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    input  logic hold,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst) q <= 1'b0;
        else     q <= set | (q & ~(clr & ~hold));
    end
endmodule

// File: rtl/can_err_irq_ctrl.sv
module can_err_irq_ctrl
    import can_eic_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int NUM_BUF     = 8,
    parameter int DATA_W      = 8,
    parameter int WARN_LVL    = 96,
    parameter int PASSIVE_LVL = 127,
    parameter int SYNC_STAGES = 2,
    localparam int IDX_W      = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [CNT_W-1:0]      rx_err_cnt,
    input  logic [CNT_W-1:0]      tx_err_cnt,
    input  logic                  tx_err_cnt_ovf,
    input  logic                  msg_accept,
    input  logic [IDX_W-1:0]      msg_buf_idx,
    input  logic [NUM_BUF-1:0]    buf_full,
    input  logic                  sleep_mode,
    input  logic                  can_rx,
    input  logic                  reg_wr,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0]     reg_wdata,
    output logic [DATA_W-1:0]     reg_rdata,
    output logic [STATUS_W-1:0]   status,
    output logic [FLAG_W-1:0]     irq_flags,
    output logic [NUM_BUF-1:0]    ovf_flags,
    output logic                  irq
);
    localparam int SIDES = 2;

    logic [CNT_W-1:0]    side_cnt [SIDES];
    logic [SIDES-1:0]    side_ovf, side_warn, side_pass, side_off;
    logic [STATUS_W-1:0] status_prev_q;
    logic                state_chg;
    logic                wr_flags, wr_enable, wr_ovf;
    logic [NUM_BUF-1:0]  ovf_set;
    logic                rx_line, rx_fall;
    logic [FLAG_W-1:0]   en_q;

    assign side_cnt[0] = rx_err_cnt;
    assign side_cnt[1] = tx_err_cnt;
    assign side_ovf    = {tx_err_cnt_ovf, 1'b0};

    for (genvar s = 0; s < SIDES; s++) begin : g_side
        err_level_fsm #(
            .CNT_W(CNT_W), .WARN_LVL(WARN_LVL), .PASSIVE_LVL(PASSIVE_LVL)
        ) u_lvl (
            .clk(clk), .rst(rst), .cnt(side_cnt[s]), .cnt_ovf(side_ovf[s]),
            .warn(side_warn[s]), .passive(side_pass[s]), .bus_off(side_off[s])
        );
    end

    always_comb begin
        status             = '0;
        status[ST_RX_WARN] = side_warn[0];
        status[ST_TX_WARN] = side_warn[1];
        status[ST_RX_PASS] = side_pass[0];
        status[ST_TX_PASS] = side_pass[1];
        status[ST_BUS_OFF] = |side_off;
    end

    always_ff @(posedge clk) begin
        if (rst) status_prev_q <= '0;
        else     status_prev_q <= status;
    end
    assign state_chg = (status != status_prev_q);

    assign wr_flags  = reg_wr && (reg_addr == ADDR_FLAGS);
    assign wr_enable = reg_wr && (reg_addr == ADDR_ENABLE);
    assign wr_ovf    = reg_wr && (reg_addr == ADDR_OVF);

    for (genvar i = 0; i < NUM_BUF; i++) begin : g_buf
        assign ovf_set[i] = msg_accept && buf_full[i] && (msg_buf_idx == IDX_W'(i));
        sticky_flag u_ovf (
            .clk(clk), .rst(rst), .set(ovf_set[i]),
            .clr(wr_ovf & reg_wdata[i]), .hold(1'b0), .q(ovf_flags[i])
        );
    end

    rx_activity_det #(.SYNC_STAGES(SYNC_STAGES)) u_act (
        .clk(clk), .rst(rst), .rx_in(can_rx), .line(rx_line), .fall(rx_fall)
    );

    sticky_flag u_err (
        .clk(clk), .rst(rst), .set(state_chg | (|ovf_set)),
        .clr(wr_flags & reg_wdata[FLG_ERR]), .hold(|ovf_flags),
        .q(irq_flags[FLG_ERR])
    );

    sticky_flag u_wake (
        .clk(clk), .rst(rst), .set(sleep_mode & rx_fall),
        .clr(wr_flags & reg_wdata[FLG_WAKE]), .hold(sleep_mode & ~rx_line),
        .q(irq_flags[FLG_WAKE])
    );

    always_ff @(posedge clk) begin
        if (rst)            en_q <= '0;
        else if (wr_enable) en_q <= reg_wdata[FLAG_W-1:0];
    end

    assign irq = |(irq_flags & en_q);

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADDR_STATUS: reg_rdata = DATA_W'(status);
            ADDR_FLAGS:  reg_rdata = DATA_W'(irq_flags);
            ADDR_ENABLE: reg_rdata = DATA_W'(en_q);
            ADDR_OVF:    reg_rdata = DATA_W'(ovf_flags);
            default:     reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/can_eic_checker.sv
module can_eic_checker
    import can_eic_pkg::*;
#(
    parameter int NUM_BUF = 8
) (
    input logic                  clk,
    input logic                  rst,
    input logic [STATUS_W-1:0]   status,
    input logic [FLAG_W-1:0]     irq_flags,
    input logic [NUM_BUF-1:0]    ovf_flags,
    input logic                  irq,
    input logic                  sleep_mode,
    input logic                  reg_wr,
    input logic [REG_ADDR_W-1:0] reg_addr
);
    a_r4_busoff_implies_tx_fault: assert property (@(posedge clk) disable iff (rst)
        status[ST_BUS_OFF] |-> (status[ST_TX_PASS] && status[ST_TX_WARN]));

    a_r3_passive_implies_warn: assert property (@(posedge clk) disable iff (rst)
        (status[ST_RX_PASS] |-> status[ST_RX_WARN]) and (status[ST_TX_PASS] |-> status[ST_TX_WARN]));

    a_r6_change_sets_err: assert property (@(posedge clk) disable iff (rst)
        (status != $past(status)) |=> irq_flags[FLG_ERR]);

    a_r5_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        !(reg_wr && reg_addr == ADDR_OVF) |=> ((ovf_flags & $past(ovf_flags)) == $past(ovf_flags)));

    a_r7_no_wake_awake: assert property (@(posedge clk) disable iff (rst)
        (!sleep_mode && !irq_flags[FLG_WAKE]) |=> !irq_flags[FLG_WAKE]);

    a_r9_err_held_by_ovf: assert property (@(posedge clk) disable iff (rst)
        ((|ovf_flags) && irq_flags[FLG_ERR]) |=> irq_flags[FLG_ERR]);

    a_r8_irq_needs_flag: assert property (@(posedge clk) disable iff (rst)
        irq |-> (|irq_flags));

    a_r11_reset_clears: assert property (@(posedge clk)
        rst |=> (status == '0 && irq_flags == '0 && ovf_flags == '0));
endmodule

bind can_err_irq_ctrl can_eic_checker #(.NUM_BUF(NUM_BUF)) u_chk (
    .clk(clk), .rst(rst), .status(status), .irq_flags(irq_flags),
    .ovf_flags(ovf_flags), .irq(irq), .sleep_mode(sleep_mode),
    .reg_wr(reg_wr), .reg_addr(reg_addr)
);

// File: tb/tb_can_err_irq_ctrl.sv
`timescale 1ns/100ps
module tb_can_err_irq_ctrl;
    localparam int NB = 3;
    localparam int IW = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [7:0] rx_err_cnt = '0, tx_err_cnt = '0;
    logic tx_err_cnt_ovf = 1'b0, msg_accept = 1'b0, sleep_mode = 1'b0, can_rx = 1'b1;
    logic [IW-1:0] msg_buf_idx = '0;
    logic [NB-1:0] buf_full = '0;
    logic reg_wr = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [4:0] status;
    logic [1:0] irq_flags;
    logic [NB-1:0] ovf_flags;
    logic irq;

    int checks = 0, errors = 0;
    bit done = 0;

    can_err_irq_ctrl #(.NUM_BUF(NB)) dut (
        .clk(clk), .rst(rst), .rx_err_cnt(rx_err_cnt), .tx_err_cnt(tx_err_cnt),
        .tx_err_cnt_ovf(tx_err_cnt_ovf), .msg_accept(msg_accept), .msg_buf_idx(msg_buf_idx),
        .buf_full(buf_full), .sleep_mode(sleep_mode), .can_rx(can_rx), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .status(status),
        .irq_flags(irq_flags), .ovf_flags(ovf_flags), .irq(irq)
    );

    always #2.5 clk = ~clk;

    // behavioural reference
    logic [4:0] m_status = '0, m_prev = '0, m_new;
    logic m_err = 0, m_wake = 0, m_s1 = 1, m_s2 = 1, m_s3 = 1;
    logic [NB-1:0] m_ovf = '0, m_set, m_clr;
    logic [1:0] m_en = '0, m_fclr;
    logic m_chg, m_fall, m_hold_w;

    function automatic logic [4:0] classify(int rx, int tx, bit txo);
        logic [4:0] v;
        v[0] = (rx >= 96);
        v[1] = txo || (tx >= 96);
        v[2] = (rx > 127);
        v[3] = txo || (tx > 127);
        v[4] = txo;
        return v;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_status = '0; m_prev = '0; m_err = 0; m_wake = 0; m_ovf = '0; m_en = '0;
            m_s1 = 1; m_s2 = 1; m_s3 = 1;
        end else begin
            m_new = classify(int'(rx_err_cnt), int'(tx_err_cnt), tx_err_cnt_ovf);
            m_chg = (m_status != m_prev);
            m_set = '0;
            if (msg_accept && int'(msg_buf_idx) < NB && buf_full[msg_buf_idx])
                m_set[msg_buf_idx] = 1'b1;
            m_fall = m_s3 && !m_s2;
            m_hold_w = sleep_mode && !m_s2;
            m_fclr = (reg_wr && reg_addr == 2'd1) ? reg_wdata[1:0] : 2'b00;
            m_clr = (reg_wr && reg_addr == 2'd3) ? reg_wdata[NB-1:0] : '0;
            m_err = m_chg || (m_set != 0) || (m_err && !(m_fclr[0] && m_ovf == 0));
            m_wake = (sleep_mode && m_fall) || (m_wake && !(m_fclr[1] && !m_hold_w));
            m_ovf = m_set | (m_ovf & ~m_clr);
            if (reg_wr && reg_addr == 2'd2) m_en = reg_wdata[1:0];
            m_prev = m_status; m_status = m_new;
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = can_rx;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int exp_rdata();
        case (reg_addr)
            2'd0: return int'(m_status);
            2'd1: return int'({m_wake, m_err});
            2'd2: return int'(m_en);
            default: return int'(m_ovf);
        endcase
    endfunction

    always @(posedge clk) begin
        #1;
        if (!done) begin
            chk("R1 rx warning", status[0], m_status[0]);
            chk("R2 tx warning", status[1], m_status[1]);
            chk("R3 passive", status[3:2], m_status[3:2]);
            chk("R4 bus-off", status[4], m_status[4]);
            chk("R5 overflow flags", ovf_flags, m_ovf);
            chk("R6 error flag", irq_flags[0], m_err);
            chk("R7 wake flag", irq_flags[1], m_wake);
            chk("R8 irq", irq, |({m_wake, m_err} & m_en));
            chk("R12 register read", reg_rdata, exp_rdata());
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #500000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        tick(3);
        rst = 0;
        tick(1);
        chk("R11 reset status", status, 0);
        chk("R11 reset flags", irq_flags, 0);
        chk("R11 reset ovf", ovf_flags, 0);
        chk("R11 reset irq", irq, 0);
        rx_err_cnt = 95; tick(2); chk("R1 below limit", status[0], 0);
        rx_err_cnt = 96; tick(2); chk("R1 at limit", status[0], 1);
        rx_err_cnt = 128; tick(2); chk("R3 rx passive", status[2], 1);
        rx_err_cnt = 127; tick(2); chk("R3 rx back to warn", status[2], 0);
        rx_err_cnt = 0;
        tx_err_cnt = 96; tick(2); chk("R2 tx warning", status[1], 1);
        tx_err_cnt = 200; tick(2); chk("R3 tx passive", status[3], 1);
        tx_err_cnt_ovf = 1; tx_err_cnt = 0; tick(2); chk("R4 bus-off", status[4], 1);
        tx_err_cnt_ovf = 0; tick(3); chk("R4 bus-off left", status, 0);
        wr(2'd2, 8'h01); chk("R8 irq from error flag", irq, 1);
        wr(2'd1, 8'h01); chk("R6 error flag cleared", irq_flags[0], 0);
        buf_full = 3'b010; msg_accept = 1; msg_buf_idx = 1; tick(1);
        msg_accept = 0; chk("R5 overflow set", ovf_flags, 3'b010);
        chk("R6 error flag from overflow", irq_flags[0], 1);
        buf_full = 3'b111; msg_accept = 1; msg_buf_idx = 3; tick(1);
        msg_accept = 0; chk("R5 out of range index", ovf_flags, 3'b010);
        wr(2'd1, 8'h01); chk("R9 clear refused", irq_flags[0], 1);
        msg_accept = 1; msg_buf_idx = 1;
        wr(2'd3, 8'h02); msg_accept = 0; chk("R10 set beats clear", ovf_flags[1], 1);
        wr(2'd3, 8'h07); chk("R5 overflow cleared", ovf_flags, 0);
        wr(2'd1, 8'h01); chk("R6 error flag clear accepted", irq_flags[0], 0);
        can_rx = 0; tick(4); chk("R7 no wake while awake", irq_flags[1], 0);
        can_rx = 1; tick(3); sleep_mode = 1;
        can_rx = 0; tick(4); chk("R7 wake on fall", irq_flags[1], 1);
        wr(2'd2, 8'h02); chk("R8 wake irq", irq, 1);
        wr(2'd1, 8'h02); chk("R9 wake clear refused", irq_flags[1], 1);
        can_rx = 1; tick(3); wr(2'd1, 8'h02); chk("R7 wake cleared", irq_flags[1], 0);
        sleep_mode = 0;
        wr(2'd0, 8'hFF); reg_addr = 2'd0; tick(1); chk("R12 status unchanged", reg_rdata, 0);
        for (int k = 0; k < 600; k++) begin
            case ($urandom_range(0, 5))
                0: rx_err_cnt = 0; 1: rx_err_cnt = 95; 2: rx_err_cnt = 96;
                3: rx_err_cnt = 127; 4: rx_err_cnt = 128; default: rx_err_cnt = 255;
            endcase
            case ($urandom_range(0, 5))
                0: tx_err_cnt = 0; 1: tx_err_cnt = 95; 2: tx_err_cnt = 96;
                3: tx_err_cnt = 127; 4: tx_err_cnt = 128; default: tx_err_cnt = 255;
            endcase
            tx_err_cnt_ovf = ($urandom_range(0, 7) == 0);
            msg_accept = $urandom_range(0, 1);
            msg_buf_idx = IW'($urandom_range(0, 3));
            buf_full = NB'($urandom_range(0, 7));
            sleep_mode = $urandom_range(0, 1);
            can_rx = $urandom_range(0, 1);
            reg_wr = ($urandom_range(0, 2) == 0);
            reg_addr = 2'($urandom_range(0, 3));
            reg_wdata = 8'($urandom_range(0, 255));
            tick(1);
        end
        reg_wr = 0; msg_accept = 0;
        tick(2);
        finish_run();
    end
endmodule